// File: doc/BRIEF.md
# Windowed Correlation Matrix Estimator

The block collects a finite record of an observed signal x and a matching clean reference d. Both arrive as signed fixed-point pairs on a valid strobe and are written into an internal record memory. Once the record holds REC_LEN pairs, a start pulse launches sequential multiply-accumulate passes.

The passes produce the TAPS-by-TAPS lagged autocorrelation matrix of x and the TAPS-entry cross-correlation vector between x and d. Each sum covers only the sample indices n = TAPS-1 .. REC_LEN-1, so every lagged term is a real sample. Each sum is then scaled to a mean over the WIN = REC_LEN-TAPS+1 full windows. These are the two operands needed to solve for least-mean-square-error FIR coefficients.

The matrix is symmetric. Only the upper triangle is accumulated, and lower entries are replayed from a small triangle store. Results stream out in row-major order, matrix first and vector second, each tagged with its indices.

Top module: `corr_est_top`

## Requirements
- R1: After reset, busy_o, res_valid_o, res_last_o and rec_full_o are all low.
- R2: While idle, each cycle with smp_valid_i high stores one (smp_obs_i, smp_ref_i) pair as record index 0, 1, 2 and so on. rec_full_o goes high once REC_LEN pairs are held. Pairs offered while rec_full_o is high are dropped and leave the results unchanged.
- R3: start_i is honoured only while idle with rec_full_o high. A start in the same cycle as the final sample write is ignored, because the record is not yet full at that edge.
- R4: Matrix entry (i,j) accumulates x(n-i)*x(n-j) over n = TAPS-1 .. REC_LEN-1, with a full-width signed accumulator of 2*DATA_W+clog2(REC_LEN) bits.
- R5: Vector entry i accumulates x(n-i)*d(n) over the same range of n.
- R6: Each sum S is normalised as (S*K + 2^(F-1)) >>> F, where F = RECIP_FRAC and K = floor((2^F + WIN/2)/WIN). The result is truncated to OUT_W bits in two's complement.
- R7: Entry (j,i) with j>i equals entry (i,j) bit for bit. It is replayed from the stored upper triangle.
- R8: Results leave with res_valid_o high. Matrix entries come first in row-major order, with res_is_vec_o=0, res_row_o=i and res_col_o=j. Vector entries follow with res_is_vec_o=1, res_row_o=i and res_col_o=0.
- R9: Exactly TAPS*TAPS+TAPS results are emitted per start. res_last_o is high only with the final vector entry.
- R10: A start pulse or sample offered while busy_o is high is ignored.
- R11: busy_o rises the cycle after an accepted start and stays high through the cycle that shows res_last_o. It then falls, and at the same time the record is emptied (rec_full_o low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Sample pair strobe |
| smp_obs_i | input | DATA_W | Observed sample, signed |
| smp_ref_i | input | DATA_W | Reference sample, signed |
| rec_full_o | output | 1 | Record memory holds REC_LEN pairs |
| start_i | input | 1 | Launch estimation pulse |
| busy_o | output | 1 | Estimation in progress |
| res_valid_o | output | 1 | Result strobe |
| res_is_vec_o | output | 1 | 1 for a cross-vector entry, 0 for a matrix entry |
| res_row_o | output | clog2(TAPS) | Row index i |
| res_col_o | output | clog2(TAPS) | Column index j, 0 for vector entries |
| res_data_o | output | OUT_W | Normalised correlation value, signed |
| res_last_o | output | 1 | Final result of the run |

## Verification
Two collisions are provoked on purpose. First, start_i is driven in the same cycle as the last sample write of a record. The bench then judges that busy_o stays low, since the record was one short when start was sampled. Second, a start pulse and a sample are driven in the cycle that shows res_last_o, while the block is retiring. The bench judges that busy_o falls, rec_full_o is low, and no second run begins. The next record then shows that the sample was not counted, because rec_full_o stays low until exactly REC_LEN fresh pairs have been written.

// File: rtl/corr_pkg.sv
`timescale 1ns/1ps
package corr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CLR, ST_ACC, ST_NORM, ST_MIRR, ST_DONE
  } corr_st_e;

  // packed upper-triangle slot of (r,c), r <= c
  function automatic int tri_slot(int r, int c, int taps);
    return r * taps - (r * (r - 1)) / 2 + (c - r);
  endfunction
endpackage

// File: rtl/corr_rec_mem.sv
`timescale 1ns/1ps
module corr_rec_mem #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 1000,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                     clk_i,
  input  logic                     wr_en_i,
  input  logic [AW-1:0]            wr_addr_i,
  input  logic signed [DATA_W-1:0] obs_i,
  input  logic signed [DATA_W-1:0] ref_i,
  input  logic [AW-1:0]            rd_lag_i,
  input  logic [AW-1:0]            rd_pair_i,
  input  logic [AW-1:0]            rd_cur_i,
  output logic signed [DATA_W-1:0] obs_lag_o,
  output logic signed [DATA_W-1:0] obs_pair_o,
  output logic signed [DATA_W-1:0] ref_cur_o
);
  logic [DATA_W-1:0] obs_mem [DEPTH];
  logic [DATA_W-1:0] ref_mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      obs_mem[wr_addr_i] <= obs_i;
      ref_mem[wr_addr_i] <= ref_i;
    end
  end

  assign obs_lag_o  = obs_mem[rd_lag_i];
  assign obs_pair_o = obs_mem[rd_pair_i];
  assign ref_cur_o  = ref_mem[rd_cur_i];
endmodule

// File: rtl/corr_mac.sv
`timescale 1ns/1ps
module corr_mac #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 42,
  parameter int OUT_W  = 32,
  parameter int WIN    = 969,
  parameter int RF     = 24
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     en_i,
  input  logic signed [DATA_W-1:0] a_i,
  input  logic signed [DATA_W-1:0] b_i,
  output logic [OUT_W-1:0]         norm_o
);
  localparam int    PROD_W = ACC_W + RF + 2;
  localparam longint RECIP = ((longint'(1) <<< RF) + longint'(WIN / 2)) / longint'(WIN);
  localparam logic signed [PROD_W-1:0] RECIP_S = PROD_W'(RECIP);
  localparam logic signed [PROD_W-1:0] RND_S   = PROD_W'(longint'(1) <<< (RF - 1));

  logic signed [2*DATA_W-1:0] prod;
  logic signed [ACC_W-1:0]    acc_q;
  logic signed [PROD_W-1:0]   acc_x, scaled, rounded;

  assign prod = a_i * b_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else if (en_i)   acc_q <= acc_q + ACC_W'(prod);
  end

  always_comb begin
    acc_x   = PROD_W'(acc_q);
    scaled  = acc_x * RECIP_S;
    rounded = scaled + RND_S;
    norm_o  = OUT_W'(rounded >>> RF);
  end

  assert_acc_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (acc_q == '0));
endmodule

// File: rtl/corr_tri_store.sv
`timescale 1ns/1ps
module corr_tri_store
  import corr_pkg::*;
#(
  parameter int OUT_W = 32,
  parameter int TAPS  = 32,
  localparam int IW   = $clog2(TAPS),
  localparam int SLOTS = TAPS * (TAPS + 1) / 2,
  localparam int SW   = $clog2(SLOTS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IW-1:0]    wr_row_i,
  input  logic [IW-1:0]    wr_col_i,
  input  logic [OUT_W-1:0] wr_data_i,
  input  logic [IW-1:0]    rd_row_i,
  input  logic [IW-1:0]    rd_col_i,
  output logic [OUT_W-1:0] rd_data_o
);
  logic [OUT_W-1:0] mem [SLOTS];
  logic [SW-1:0]    wr_slot, rd_slot;

  assign wr_slot = SW'(tri_slot(int'(wr_row_i), int'(wr_col_i), TAPS));
  assign rd_slot = SW'(tri_slot(int'(rd_row_i), int'(rd_col_i), TAPS));

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wr_slot] <= wr_data_i;
  end

  assign rd_data_o = mem[rd_slot];

  assert_upper_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (wr_row_i <= wr_col_i));
endmodule

// File: rtl/corr_est_top.sv
`timescale 1ns/1ps
module corr_est_top
  import corr_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int TAPS       = 32,
  parameter int REC_LEN    = 1000,
  parameter int OUT_W      = 2 * DATA_W,
  parameter int RECIP_FRAC = 24
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        smp_valid_i,
  input  logic signed [DATA_W-1:0]    smp_obs_i,
  input  logic signed [DATA_W-1:0]    smp_ref_i,
  output logic                        rec_full_o,
  input  logic                        start_i,
  output logic                        busy_o,
  output logic                        res_valid_o,
  output logic                        res_is_vec_o,
  output logic [$clog2(TAPS)-1:0]     res_row_o,
  output logic [$clog2(TAPS)-1:0]     res_col_o,
  output logic [OUT_W-1:0]            res_data_o,
  output logic                        res_last_o
);
  localparam int ACC_W = 2 * DATA_W + $clog2(REC_LEN);
  localparam int WIN   = REC_LEN - TAPS + 1;
  localparam int IW    = $clog2(TAPS);
  localparam int AW    = $clog2(REC_LEN);
  localparam int CW    = $clog2(REC_LEN + 1);

  corr_st_e       state_q;
  logic [CW-1:0]  wr_cnt_q;
  logic [AW-1:0]  n_q;
  logic [IW-1:0]  row_q, col_q;
  logic           vec_q;

  logic [IW-1:0]  nxt_row, nxt_col;
  logic           nxt_vec, nxt_fin, nxt_mirr;
  logic           wr_en;
  logic signed [DATA_W-1:0] obs_lag, obs_pair, ref_cur, mac_b;
  logic [OUT_W-1:0] norm_val, tri_val;

  assign rec_full_o = (wr_cnt_q == CW'(REC_LEN));
  assign busy_o     = (state_q != ST_IDLE);
  assign wr_en      = (state_q == ST_IDLE) && smp_valid_i && !rec_full_o;
  assign mac_b      = vec_q ? ref_cur : obs_pair;

  corr_rec_mem #(.DATA_W(DATA_W), .DEPTH(REC_LEN)) rec_i (
    .clk_i      (clk_i),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_cnt_q[AW-1:0]),
    .obs_i      (smp_obs_i),
    .ref_i      (smp_ref_i),
    .rd_lag_i   (n_q - AW'(row_q)),
    .rd_pair_i  (n_q - AW'(col_q)),
    .rd_cur_i   (n_q),
    .obs_lag_o  (obs_lag),
    .obs_pair_o (obs_pair),
    .ref_cur_o  (ref_cur)
  );

  corr_mac #(.DATA_W(DATA_W), .ACC_W(ACC_W), .OUT_W(OUT_W), .WIN(WIN), .RF(RECIP_FRAC)) mac_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q == ST_CLR),
    .en_i   (state_q == ST_ACC),
    .a_i    (obs_lag),
    .b_i    (mac_b),
    .norm_o (norm_val)
  );

  // lower entry (row,col) replays upper slot (col,row)
  corr_tri_store #(.OUT_W(OUT_W), .TAPS(TAPS)) tri_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   ((state_q == ST_NORM) && !vec_q),
    .wr_row_i  (row_q),
    .wr_col_i  (col_q),
    .wr_data_i (norm_val),
    .rd_row_i  (col_q),
    .rd_col_i  (row_q),
    .rd_data_o (tri_val)
  );

  // next output entry in row-major order
  always_comb begin
    nxt_row = row_q;
    nxt_col = col_q;
    nxt_vec = vec_q;
    nxt_fin = 1'b0;
    if (vec_q) begin
      nxt_row = row_q + IW'(1);
      nxt_col = '0;
      nxt_fin = (row_q == IW'(TAPS - 1));
    end else if (col_q == IW'(TAPS - 1)) begin
      nxt_col = '0;
      if (row_q == IW'(TAPS - 1)) begin
        nxt_vec = 1'b1;
        nxt_row = '0;
      end else begin
        nxt_row = row_q + IW'(1);
      end
    end else begin
      nxt_col = col_q + IW'(1);
    end
    nxt_mirr = !nxt_vec && (nxt_col < nxt_row);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      wr_cnt_q     <= '0;
      n_q          <= '0;
      row_q        <= '0;
      col_q        <= '0;
      vec_q        <= 1'b0;
      res_valid_o  <= 1'b0;
      res_is_vec_o <= 1'b0;
      res_row_o    <= '0;
      res_col_o    <= '0;
      res_data_o   <= '0;
      res_last_o   <= 1'b0;
    end else begin
      res_valid_o <= 1'b0;
      res_last_o  <= 1'b0;
      if (wr_en) wr_cnt_q <= wr_cnt_q + CW'(1);
      unique case (state_q)
        ST_IDLE: begin
          if (start_i && rec_full_o) begin
            row_q   <= '0;
            col_q   <= '0;
            vec_q   <= 1'b0;
            state_q <= ST_CLR;
          end
        end
        ST_CLR: begin
          n_q     <= AW'(TAPS - 1);
          state_q <= ST_ACC;
        end
        ST_ACC: begin
          n_q <= n_q + AW'(1);
          if (n_q == AW'(REC_LEN - 1)) state_q <= ST_NORM;
        end
        ST_NORM, ST_MIRR: begin
          res_valid_o  <= 1'b1;
          res_is_vec_o <= vec_q;
          res_row_o    <= row_q;
          res_col_o    <= col_q;
          res_data_o   <= (state_q == ST_NORM) ? norm_val : tri_val;
          res_last_o   <= nxt_fin;
          row_q        <= nxt_row;
          col_q        <= nxt_col;
          vec_q        <= nxt_vec;
          if (nxt_fin)       state_q <= ST_DONE;
          else if (nxt_mirr) state_q <= ST_MIRR;
          else               state_q <= ST_CLR;
        end
        ST_DONE: begin
          wr_cnt_q <= '0;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_last_on_vec_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_last_o |-> (res_valid_o && res_is_vec_o && res_row_o == IW'(TAPS - 1)));
  assert_valid_in_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> busy_o);
  assert_full_while_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> rec_full_o);
  assert_start_needs_full_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i && rec_full_o));
  assert_vec_col_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_is_vec_o) |-> (res_col_o == '0));
  assert_mirror_lower_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_MIRR) |-> (col_q < row_q && !vec_q));
endmodule

// File: tb/corr_est_top_tb_top.sv
`timescale 1ns/1ps
module corr_est_top_tb_top;
  localparam int DW = 8;
  localparam int L  = 4;
  localparam int N  = 12;
  localparam int OW = 16;
  localparam int RF = 16;
  localparam int WIN = N - L + 1;
  localparam longint K = ((longint'(1) <<< RF) + WIN / 2) / WIN;
  localparam int NOUT = L * L + L;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic signed [DW-1:0] smp_obs = '0, smp_ref = '0;
  logic start = 1'b0;
  logic rec_full, busy, res_valid, res_is_vec, res_last;
  logic [1:0] res_row, res_col;
  logic [OW-1:0] res_data;

  always #10 clk = ~clk;

  corr_est_top #(.DATA_W(DW), .TAPS(L), .REC_LEN(N), .OUT_W(OW), .RECIP_FRAC(RF)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(smp_valid), .smp_obs_i(smp_obs),
    .smp_ref_i(smp_ref), .rec_full_o(rec_full), .start_i(start), .busy_o(busy),
    .res_valid_o(res_valid), .res_is_vec_o(res_is_vec), .res_row_o(res_row),
    .res_col_o(res_col), .res_data_o(res_data), .res_last_o(res_last)
  );

  int total = 0, bad = 0;
  int xs[N], ds[N];
  int got_n = 0;
  logic [OW-1:0] got_d [NOUT + 4];
  logic got_v [NOUT + 4];
  logic got_l [NOUT + 4];
  int got_r [NOUT + 4], got_c [NOUT + 4];

  always @(negedge clk) begin
    if (res_valid) begin
      if (got_n < NOUT + 4) begin
        got_d[got_n] = res_data;
        got_v[got_n] = res_is_vec;
        got_l[got_n] = res_last;
        got_r[got_n] = int'(res_row);
        got_c[got_n] = int'(res_col);
      end
      got_n = got_n + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [OW-1:0] expect_val(input bit vec, input int i, input int j);
    longint acc = 0;
    longint r;
    for (int n = L - 1; n < N; n++)
      acc += longint'(xs[n - i]) * longint'(vec ? ds[n] : xs[n - j]);
    r = (acc * K + (longint'(1) <<< (RF - 1))) >>> RF;
    return r[OW-1:0];
  endfunction

  task automatic fill(input int p);
    int s = 7 + p;
    for (int n = 0; n < N; n++) begin
      case (p)
        0: begin xs[n] = -128; ds[n] = -128; end
        1: begin xs[n] = (n % 2) ? 127 : -127; ds[n] = (n % 3) * 50 - 50; end
        2: begin
          s = s * 1103515245 + 12345; xs[n] = int'($signed(s[23:16]));
          s = s * 1103515245 + 12345; ds[n] = int'($signed(s[23:16]));
        end
        default: begin xs[n] = n * 21 - 120; ds[n] = 100 - n * 17; end
      endcase
    end
  endtask

  task automatic load(input bit start_on_last);
    for (int n = 0; n < N; n++) begin
      @(negedge clk);
      if (n == N - 1) check(rec_full == 1'b0, "R2", "full before last sample", rec_full, 0);
      smp_valid = 1'b1;
      smp_obs = DW'(xs[n]);
      smp_ref = DW'(ds[n]);
      start = start_on_last && (n == N - 1);
    end
    @(negedge clk);
    smp_valid = 1'b0;
    start = 1'b0;
    check(rec_full == 1'b1, "R2", "full after record", rec_full, 1);
    if (start_on_last) check(busy == 1'b0, "R3", "start with last sample", busy, 0);
    // extra pairs while full must be dropped
    smp_valid = 1'b1; smp_obs = 8'sh55; smp_ref = -8'sd1;
    repeat (2) @(negedge clk);
    smp_valid = 1'b0;
    check(busy == 1'b0, "R2", "busy after extra pairs", busy, 0);
  endtask

  task automatic run_and_check(input int p);
    int cyc = 0;
    got_n = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy == 1'b1, "R11", "busy after start", busy, 1);
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc == 15) begin
        start = 1'b1; smp_valid = 1'b1; smp_obs = 8'sh11; smp_ref = 8'sh22;
      end else if (cyc == 16) begin
        start = 1'b0; smp_valid = 1'b0;
      end
      if (res_last) break;
    end
    check(busy == 1'b1, "R11", "busy with last", busy, 1);
    // collision: start and sample on the last-result cycle
    start = 1'b1; smp_valid = 1'b1; smp_obs = 8'sh33; smp_ref = 8'sh44;
    @(negedge clk);
    start = 1'b0; smp_valid = 1'b0;
    check(busy == 1'b0, "R11", "busy after last", busy, 0);
    check(rec_full == 1'b0, "R11", "record emptied", rec_full, 0);
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R10", "start at retire ignored", busy, 0);
    check(got_n == NOUT, "R9", "result count", got_n, NOUT);
    for (int k = 0; k < NOUT && k < got_n; k++) begin
      bit vec = (k >= L * L);
      int er = vec ? k - L * L : k / L;
      int ec = vec ? 0 : k % L;
      int ui = (er <= ec) ? er : ec;
      int uj = (er <= ec) ? ec : er;
      logic [OW-1:0] ev = vec ? expect_val(1'b1, er, 0) : expect_val(1'b0, ui, uj);
      check(got_v[k] == vec && got_r[k] == er && got_c[k] == ec, "R8",
            $sformatf("tags k=%0d p=%0d", k, p), got_r[k] * 16 + got_c[k], er * 16 + ec);
      check(got_l[k] == (k == NOUT - 1), "R9", $sformatf("last k=%0d", k), got_l[k], k == NOUT - 1);
      if (vec)
        check(got_d[k] == ev, "R5", $sformatf("vec i=%0d p=%0d", er, p),
              $signed(got_d[k]), $signed(ev));
      else if (ec < er)
        check(got_d[k] == ev, "R7", $sformatf("mirror %0d,%0d p=%0d", er, ec, p),
              $signed(got_d[k]), $signed(ev));
      else
        check(got_d[k] == ev, "R4 R6", $sformatf("mat %0d,%0d p=%0d", er, ec, p),
              $signed(got_d[k]), $signed(ev));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog R11 actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0 && res_valid == 0 && rec_full == 0 && res_last == 0, "R1", "reset state",
          {busy, res_valid, rec_full, res_last}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check(busy == 1'b0, "R3", "start on empty record", busy, 0);
    for (int p = 0; p < 4; p++) begin
      fill(p);
      load(p == 0);
      run_and_check(p);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule